// File: doc/BRIEF.md
# Interrupt Class and Mask Unit

This unit gathers single-cycle event pulses from a bus-interface controller into three 8-bit status registers: two for bus-side events and one for DMA-side events. A matching 8-bit enable register stands beside each status register. The unit decides which events must stop the on-chip script engine. It also decides which events must reach the host through a summary pending flag and an active-low interrupt pin.

Each source belongs to one of two classes. A nonfatal source lets the script engine keep running. A fatal source stops it. The class depends on whether the controller runs as initiator or target. In target mode a configuration bit decides the class of the attention source.

The enable bit controls only the host notification. A masked event is still recorded in status. A masked fatal event still stops the engine. A plain register port gives read/write access to the enable registers. Status registers clear themselves after they are read.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Every event pulse sets its status bit whether or not it is enabled, and the bit stays set until the status register is read.
- R2: Status addresses are 0 (bus group A), 1 (bus group B) and 2 (DMA). A read returns the current status in the same cycle. The register is cleared at the clock edge that ends the read. An event arriving in that same cycle stays set.
- R3: In initiator mode (`target_mode_i`=0), only group A bits 0 (function complete), 1 (selected) and 2 (reselected) and group B bits 0 (handshake timer) and 1 (general timer) are nonfatal. Every other bus bit is fatal.
- R4: In target mode, group A bit 3 (attention from initiator) is nonfatal when `atn_nohalt_i`=1. It is fatal when `atn_nohalt_i`=0. All other bits keep their R3 class.
- R5: DMA bit 0 (interrupt-on-the-fly) is nonfatal in every mode. DMA bits 1 to 7 are fatal.
- R6: `halt_o` is high for exactly the one cycle after a cycle in which at least one fatal event arrived, whether that event is enabled or masked. Nonfatal events never raise `halt_o`.
- R7: `scsi_pend_o` is high exactly while some bit is set in both a bus status register and its enable register.
- R8: `irq_no` is low exactly while some bit is set in both any status register and its enable register. A masked event alone never pulls it low.
- R9: Enable registers sit at addresses 3, 4 and 5 (group A, group B, DMA). They are written and read back through the port. Writes to status addresses have no effect.
- R10: After reset all status and enable bits are 0, `halt_o`=0, `scsi_pend_o`=0 and `irq_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| target_mode_i | input | 1 | 1 = target mode, 0 = initiator mode |
| atn_nohalt_i | input | 1 | Target mode: 1 makes the attention source nonfatal |
| scsi_a_evt_i | input | 8 | Bus group A event pulses |
| scsi_b_evt_i | input | 8 | Bus group B event pulses |
| dma_evt_i | input | 8 | DMA event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| scsi_pend_o | output | 1 | Summary of enabled bus status |
| irq_no | output | 1 | Interrupt request, active low, level |
| halt_o | output | 1 | One-cycle request to stop the script engine |

## Verification
The embedded assertions check several rules on every cycle:
- every event lands in status on the next edge;
- a read leaves only the events that arrived with it;
- a fatal arrival is followed by a halt pulse, and a purely nonfatal cycle is not;
- the interrupt pin stays high while no enabled status bit is set.

Only the bench scenarios can show the mode-dependent class of each single source. This covers the attention bit under both settings of its control bit. The bench scenarios also show that enable bits read back at their addresses and that writes to status addresses change nothing.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned N_BANK  = 3;
  localparam int unsigned AW      = 3;
  localparam int unsigned BANK_A  = 0;
  localparam int unsigned BANK_B  = 1;
  localparam int unsigned BANK_D  = 2;
  localparam int unsigned EN_BASE = 3;
  localparam int unsigned ATN_BIT = 3;
  // nonfatal sets per bank, independent of mode
  localparam logic [DW-1:0] NF_A = 8'b0000_0111;
  localparam logic [DW-1:0] NF_B = 8'b0000_0011;
  localparam logic [DW-1:0] NF_D = 8'b0000_0001;
  typedef logic [N_BANK-1:0][DW-1:0] bank_vec_t;
endpackage

// File: rtl/irq_src_class.sv
module irq_src_class
  import irq_mask_pkg::*;
(
  input  logic      target_mode_i,
  input  logic      atn_nohalt_i,
  output bank_vec_t fatal_o
);
  logic [DW-1:0] nf_a;

  always_comb begin
    nf_a = NF_A;
    if (target_mode_i && atn_nohalt_i) nf_a[ATN_BIT] = 1'b1;
    fatal_o[BANK_A] = ~nf_a;
    fatal_o[BANK_B] = ~NF_B;
    fatal_o[BANK_D] = ~NF_D;
  end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (clr_i) stat_q <= evt_i;  // simultaneous event survives the clear
    else            stat_q <= stat_q | evt_i;
  end

  assign stat_o = stat_q;

  a_r1_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (stat_o == $past(evt_i)));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          target_mode_i,
  input  logic          atn_nohalt_i,
  input  logic [DW-1:0] scsi_a_evt_i,
  input  logic [DW-1:0] scsi_b_evt_i,
  input  logic [DW-1:0] dma_evt_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          scsi_pend_o,
  output logic          irq_no,
  output logic          halt_o
);
  bank_vec_t evt, stat, en_q, fatal;
  logic [N_BANK-1:0] clr, live, fatal_hit;
  logic halt_q;

  assign evt[BANK_A] = scsi_a_evt_i;
  assign evt[BANK_B] = scsi_b_evt_i;
  assign evt[BANK_D] = dma_evt_i;

  irq_src_class u_class (
    .target_mode_i (target_mode_i),
    .atn_nohalt_i  (atn_nohalt_i),
    .fatal_o       (fatal)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign clr[b] = reg_re_i && (reg_addr_i == AW'(b));

    irq_stat_bank #(.W(DW)) u_stat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[b]),
      .clr_i  (clr[b]),
      .stat_o (stat[b])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[b] <= '0;
      else if (reg_we_i && reg_addr_i == AW'(EN_BASE + b)) en_q[b] <= reg_wdata_i;
    end

    assign live[b]      = |(stat[b] & en_q[b]);
    assign fatal_hit[b] = |(evt[b] & fatal[b]);
  end

  // halt ignores the mask: a fatal source always stops the engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else         halt_q <= |fatal_hit;
  end

  assign halt_o      = halt_q;
  assign scsi_pend_o = live[BANK_A] | live[BANK_B];
  assign irq_no      = ~(scsi_pend_o | live[BANK_D]);

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < N_BANK; b++) begin
      if (reg_addr_i == AW'(b))           reg_rdata_o = stat[b];
      if (reg_addr_i == AW'(EN_BASE + b)) reg_rdata_o = en_q[b];
    end
  end

  a_r6_fatal_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fatal_hit) |=> halt_o);

  a_r6_nonfatal_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fatal_hit == '0) |=> !halt_o);

  a_r8_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((stat[BANK_A] & en_q[BANK_A]) == '0) && ((stat[BANK_B] & en_q[BANK_B]) == '0)
     && ((stat[BANK_D] & en_q[BANK_D]) == '0)) |-> irq_no);

  a_r7_pend_drives_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scsi_pend_o |-> !irq_no);
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tgt = 1'b0, atn = 1'b0;
  logic [7:0] ea = '0, eb = '0, ed = '0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic pend, irq_n, halt;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_stat [3];
  logic [7:0] m_en   [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .target_mode_i(tgt), .atn_nohalt_i(atn),
    .scsi_a_evt_i(ea), .scsi_b_evt_i(eb), .dma_evt_i(ed),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .scsi_pend_o(pend), .irq_no(irq_n), .halt_o(halt)
  );

  function automatic logic [7:0] fatal_of(int b, logic t, logic a);
    logic [7:0] nf;
    case (b)
      0: begin nf = 8'h07; if (t && a) nf[3] = 1'b1; end
      1: nf = 8'h03;
      default: nf = 8'h01;
    endcase
    return ~nf;
  endfunction

  function automatic logic [7:0] model_read(logic [2:0] a);
    if (a < 3) return m_stat[a];
    if (a < 6) return m_en[a-3];
    return 8'h00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] a0, b0, d0, input logic w, r,
                      input logic [2:0] ad, input logic [7:0] wd);
    logic [7:0] e [3];
    logic fat;
    logic p_exp, i_exp;
    @(negedge clk);
    ea = a0; eb = b0; ed = d0; we = w; re = r; addr = ad; wdata = wd;
    #1;
    if (r) check(ad < 3 ? "R2 read" : "R9 read", rdata, model_read(ad));
    e[0] = a0; e[1] = b0; e[2] = d0;
    fat = 1'b0;
    for (int b = 0; b < 3; b++) begin
      if ((e[b] & fatal_of(b, tgt, atn)) != 0) fat = 1'b1;
      if (r && ad == 3'(b)) m_stat[b] = e[b];
      else                  m_stat[b] = m_stat[b] | e[b];
    end
    if (w && ad >= 3 && ad < 6) m_en[ad-3] = wd;
    @(posedge clk); #1;
    p_exp = ((m_stat[0] & m_en[0]) != 0) || ((m_stat[1] & m_en[1]) != 0);
    i_exp = ~(p_exp || ((m_stat[2] & m_en[2]) != 0));
    check("R6 halt", halt, fat);
    check("R7 pend", pend, p_exp);
    check("R8 irq", irq_n, i_exp);
    ea = '0; eb = '0; ed = '0; we = 1'b0; re = 1'b0;
  endtask

  task automatic idle();
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    void'($urandom(32'h1d5e));
    for (int b = 0; b < 3; b++) begin m_stat[b] = '0; m_en[b] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check("R10 halt", halt, 1'b0);
    check("R10 pend", pend, 1'b0);
    check("R10 irq", irq_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 6; a++) step(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'(a), 8'h00);  // R10 zero reads

    // R1/R8: masked nonfatal latches, no irq, no halt
    step(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 8'h00);
    // R6: masked fatal halts without irq
    step(8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
    idle();
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 8'h00);
    // R9: enables written, status writes ignored
    step(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd3, 8'hff);
    step(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd4, 8'h5a);
    step(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd5, 8'hc3);
    step(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'd1, 8'hff);
    for (int a = 1; a < 6; a++) step(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'(a), 8'h00);
    // R7: enabled nonfatal raises pend, no halt
    step(8'h02, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
    // R2: read with simultaneous event retains it
    step(8'h04, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 8'h00);
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 8'h00);
    // R5: on-the-fly is nonfatal, other DMA bits fatal
    step(8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 3'd0, 8'h00);
    step(8'h00, 8'h00, 8'h80, 1'b0, 1'b0, 3'd0, 8'h00);
    step(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 8'h00);
    // R3/R4: attention bit per mode and control
    for (int m = 0; m < 4; m++) begin
      tgt = m[1]; atn = m[0];
      step(8'h08, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
      step(8'h00, 8'h03, 8'h00, 1'b0, 1'b1, 3'd0, 8'h00);
      step(8'h00, 8'h04, 8'h00, 1'b0, 1'b1, 3'd1, 8'h00);
    end
    // R3: single-source sweep in initiator mode
    tgt = 1'b0; atn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
      step(8'h00, 8'(1 << i), 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
    end
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      tgt = r[0]; atn = r[1];
      step(8'($urandom & $urandom & $urandom), 8'($urandom & $urandom & $urandom),
           8'($urandom & $urandom & $urandom), r[4:2] == 0, r[7:5] < 2,
           3'(r[10:8] % 7), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule